// File: doc/BRIEF.md
# Serial Port Byte FIFO Pair with Trigger and DMA Request Logic

This block sits between a host-side data path and a serial framer. It holds one
byte queue for the outgoing direction and one for the incoming direction, each
of sixteen bytes. The host pushes transmit bytes and the framer pulls them. The
framer pushes received bytes and the host pulls them. Every data path is a
valid/ready stream. A byte moves on a rising clock edge only when valid and
ready are both high. A producer must hold its data and valid steady until ready
is seen. Ready on a write side drops when the queue is at capacity. Valid on a
read side is high whenever the queue holds a byte, and the head byte is
presented directly (first-word fall-through).

A queue-enable input selects between sixteen-entry operation and a single-byte
holding mode. The holding mode behaves like a classic double-buffered register
pair. Each direction has its own three-bit threshold select, expressed in
eighths of the depth. From the fill counts the block derives the interrupt
lines, the DMA single and burst requests, and the status flags. An
end-of-transmission line combines the transmit queue state with a busy
indication from the framer's shift register.

Top module: `sfifo_pair`

## Requirements
- R1: Each direction stores 16 bytes and delivers them in arrival order; the head byte is shown on the read data port whenever read valid is high.
- R2: Write ready is low while a queue holds its capacity, and a write offered while ready is low changes neither the level nor the stored data; a write and a read in the same cycle leave the level unchanged.
- R3: With `fifo_en` low, each direction has a capacity of one byte, so a second write is refused until the held byte is read.
- R4: Threshold select codes map to entries as 0→2, 1→4, 2→8, 3→12, and 4 through 7→14.
- R5: With `fifo_en` high, `rx_irq` and `rx_dma_burst` are high exactly when the receive level is at or above the threshold; with `fifo_en` low, they are high exactly when the receive holding register is occupied.
- R6: With `fifo_en` high, `tx_irq` and `tx_dma_burst` are high exactly when the transmit level is at or below the threshold; with `fifo_en` low, they are high exactly when the transmit holding register is empty.
- R7: `rx_dma_single` is high exactly when the receive level is at least one.
- R8: `tx_dma_single` is high exactly when the transmit queue has at least one free entry within its current capacity.
- R9: `eot_irq` is high exactly when the transmit queue is empty and `shift_busy` is low.
- R10: After reset both levels are zero, both empty flags are high and both full flags are low; each level output equals the stored byte count, and each full flag is high when that count has reached the capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1: 16-entry queues, 0: single-byte holding mode |
| tx_trig_sel | input | 3 | Transmit threshold select (R4 encoding) |
| rx_trig_sel | input | 3 | Receive threshold select (R4 encoding) |
| shift_busy | input | 1 | Framer shift register still sending |
| tx_in_valid | input | 1 | Host offers a transmit byte |
| tx_in_ready | output | 1 | Transmit queue accepts a byte |
| tx_in_data | input | 8 | Transmit byte from host |
| tx_out_valid | output | 1 | Transmit head byte available to framer |
| tx_out_ready | input | 1 | Framer takes the transmit head byte |
| tx_out_data | output | 8 | Transmit head byte |
| rx_in_valid | input | 1 | Framer offers a received byte |
| rx_in_ready | output | 1 | Receive queue accepts a byte |
| rx_in_data | input | 8 | Received byte from framer |
| rx_out_valid | output | 1 | Receive head byte available to host |
| rx_out_ready | input | 1 | Host takes the receive head byte |
| rx_out_data | output | 8 | Receive head byte |
| tx_irq | output | 1 | Transmit level interrupt |
| rx_irq | output | 1 | Receive level interrupt |
| eot_irq | output | 1 | End-of-transmission interrupt |
| tx_dma_single | output | 1 | Transmit single-transfer request |
| tx_dma_burst | output | 1 | Transmit burst request |
| rx_dma_single | output | 1 | Receive single-transfer request |
| rx_dma_burst | output | 1 | Receive burst request |
| tx_full | output | 1 | Transmit queue at capacity |
| tx_empty | output | 1 | Transmit queue empty |
| tx_level | output | 5 | Transmit byte count |
| rx_full | output | 1 | Receive queue at capacity |
| rx_empty | output | 1 | Receive queue empty |
| rx_level | output | 5 | Receive byte count |

## Verification
The threshold logic is driven with fill counts placed just below, exactly on,
and just above each of the five thresholds. This separates an off-by-one
comparison from a correct one, and it separates the at-or-above receive test
from the at-or-below transmit test. An unused select code and holding mode with
zero, one and several offered bytes show whether the default mapping and the
one-byte capacity are honoured. A distinct sixteen-byte pattern checks the
ordering. Writes offered while full, a concurrent read and write, and the
shift-busy toggling of end-of-transmission check the back-pressure and the
completion conditions.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int unsigned BYTE_W = 8;

  // Number of eighths of the depth selected by a threshold code.
  function automatic int unsigned trig_eighths(input logic [2:0] sel);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 6;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/sfifo_queue.sv
module sfifo_queue #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          deep_mode,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] count, capacity;
  logic          do_push, do_pop;

  assign capacity  = deep_mode ? LW'(DEPTH) : LW'(1);
  assign full      = (count >= capacity);
  assign empty     = (count == '0);
  assign in_ready  = !full;
  assign out_valid = !empty;
  assign out_data  = mem[rd_ptr];
  assign level     = count;
  assign do_push   = in_valid && in_ready;
  assign do_pop    = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + LW'(1);
        2'b01:   count <= count - LW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= in_data;
  end
endmodule

// File: rtl/sfifo_trigger.sv
module sfifo_trigger
  import sfifo_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter bit          IS_TX  = 1'b0,
  localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic          deep_mode,
  input  logic [2:0]    sel,
  input  logic [LW-1:0] level,
  output logic          irq,
  output logic          dma_single,
  output logic          dma_burst
);
  logic [LW-1:0] thresh;
  logic          hit;

  assign thresh = LW'((DEPTH * trig_eighths(sel)) / 8);

  generate
    if (IS_TX) begin : g_tx
      always_comb begin
        dma_single = deep_mode ? (level < LW'(DEPTH)) : (level == '0);
        hit        = deep_mode ? (level <= thresh)    : (level == '0);
      end
    end else begin : g_rx
      always_comb begin
        dma_single = (level != '0);
        hit        = deep_mode ? (level >= thresh) : (level != '0);
      end
    end
  endgenerate

  assign irq       = hit;
  assign dma_burst = hit;
endmodule

// File: rtl/sfifo_pair.sv
module sfifo_pair
  import sfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic [2:0]        tx_trig_sel,
  input  logic [2:0]        rx_trig_sel,
  input  logic              shift_busy,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [BYTE_W-1:0] tx_in_data,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [BYTE_W-1:0] tx_out_data,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic [BYTE_W-1:0] rx_in_data,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic [BYTE_W-1:0] rx_out_data,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic              eot_irq,
  output logic              tx_dma_single,
  output logic              tx_dma_burst,
  output logic              rx_dma_single,
  output logic              rx_dma_burst,
  output logic              tx_full,
  output logic              tx_empty,
  output logic [LW-1:0]     tx_level,
  output logic              rx_full,
  output logic              rx_empty,
  output logic [LW-1:0]     rx_level
);
  sfifo_queue #(.DEPTH(DEPTH), .DW(BYTE_W)) u_txq (
    .clk, .rst_n, .deep_mode(fifo_en),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data),
    .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  sfifo_queue #(.DEPTH(DEPTH), .DW(BYTE_W)) u_rxq (
    .clk, .rst_n, .deep_mode(fifo_en),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready), .out_data(rx_out_data),
    .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  sfifo_trigger #(.DEPTH(DEPTH), .IS_TX(1'b1)) u_txtrig (
    .deep_mode(fifo_en), .sel(tx_trig_sel), .level(tx_level),
    .irq(tx_irq), .dma_single(tx_dma_single), .dma_burst(tx_dma_burst)
  );

  sfifo_trigger #(.DEPTH(DEPTH), .IS_TX(1'b0)) u_rxtrig (
    .deep_mode(fifo_en), .sel(rx_trig_sel), .level(rx_level),
    .irq(rx_irq), .dma_single(rx_dma_single), .dma_burst(rx_dma_burst)
  );

  assign eot_irq = tx_empty && !shift_busy;
endmodule

// File: rtl/sfifo_pair_chk.sv
module sfifo_pair_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          tx_in_valid,
  input logic          tx_in_ready,
  input logic          tx_out_valid,
  input logic          tx_out_ready,
  input logic          rx_in_valid,
  input logic          rx_in_ready,
  input logic          rx_out_valid,
  input logic          rx_out_ready,
  input logic          rx_dma_single,
  input logic          eot_irq,
  input logic          tx_full,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= LW'(DEPTH) && rx_level <= LW'(DEPTH)); // R1

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !tx_in_ready); // R2

  AST_RX_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_in_ready && !(rx_out_valid && rx_out_ready))
      |=> rx_level == $past(rx_level) + LW'(1)); // R2

  AST_TX_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && tx_in_ready && tx_out_valid && tx_out_ready)
      |=> tx_level == $past(tx_level)); // R2

  AST_BYPASS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && rx_level != '0) |-> !rx_in_ready); // R3

  AST_RX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_single == rx_out_valid); // R7

  AST_EOT_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && tx_in_ready) |=> !eot_irq); // R9
endmodule

bind sfifo_pair sfifo_pair_chk #(.DEPTH(DEPTH)) u_chk (
  .clk, .rst_n, .fifo_en,
  .tx_in_valid, .tx_in_ready, .tx_out_valid, .tx_out_ready,
  .rx_in_valid, .rx_in_ready, .rx_out_valid, .rx_out_ready,
  .rx_dma_single, .eot_irq, .tx_full, .tx_level, .rx_level
);

// File: tb/sfifo_pair_bench.sv
module sfifo_pair_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b1;
  logic [2:0] tx_trig_sel = '0, rx_trig_sel = '0;
  logic       shift_busy = 1'b0;
  logic       tx_in_valid = 1'b0, tx_out_ready = 1'b0;
  logic       rx_in_valid = 1'b0, rx_out_ready = 1'b0;
  logic [7:0] tx_in_data = '0, rx_in_data = '0;
  logic       tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid;
  logic [7:0] tx_out_data, rx_out_data;
  logic       tx_irq, rx_irq, eot_irq;
  logic       tx_dma_single, tx_dma_burst, rx_dma_single, rx_dma_burst;
  logic       tx_full, tx_empty, rx_full, rx_empty;
  logic [4:0] tx_level, rx_level;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  sfifo_pair u_sfifo_pair (.*);

  // {en, sel[2:0], count[4:0], exp_rx_irq, exp_tx_irq}
  localparam logic [10:0] VEC [13] = '{
    {1'b1, 3'd0, 5'd2,  1'b1, 1'b1},
    {1'b1, 3'd0, 5'd3,  1'b1, 1'b0},
    {1'b1, 3'd1, 5'd3,  1'b0, 1'b1},
    {1'b1, 3'd1, 5'd4,  1'b1, 1'b1},
    {1'b1, 3'd2, 5'd8,  1'b1, 1'b1},
    {1'b1, 3'd2, 5'd9,  1'b1, 1'b0},
    {1'b1, 3'd3, 5'd11, 1'b0, 1'b1},
    {1'b1, 3'd3, 5'd13, 1'b1, 1'b0},
    {1'b1, 3'd4, 5'd14, 1'b1, 1'b1},
    {1'b1, 3'd4, 5'd16, 1'b1, 1'b0},
    {1'b0, 3'd2, 5'd0,  1'b0, 1'b1},
    {1'b0, 3'd2, 5'd3,  1'b1, 1'b0},
    {1'b1, 3'd5, 5'd13, 1'b0, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drain();
    @(negedge clk);
    tx_out_ready = 1'b1;
    rx_out_ready = 1'b1;
    for (int i = 0; i < 20; i++) @(negedge clk);
    tx_out_ready = 1'b0;
    rx_out_ready = 1'b0;
  endtask

  // Offers n writes on both directions, one per cycle, starting at a negedge.
  task automatic push_both(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      tx_in_valid = 1'b1; tx_in_data = 8'(base + i);
      rx_in_valid = 1'b1; rx_in_data = 8'(base + i);
      @(negedge clk);
    end
    tx_in_valid = 1'b0;
    rx_in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(rx_level == 0 && tx_level == 0, "R10 reset levels", int'(rx_level) + int'(tx_level), 0);
    check(rx_empty && tx_empty && !rx_full && !tx_full, "R10 reset flags",
          {rx_empty, tx_empty, rx_full, tx_full}, 4'b1100);
    check(tx_dma_single == 1'b1, "R8 reset tx single", tx_dma_single, 1);
    check(rx_dma_single == 1'b0, "R7 reset rx single", rx_dma_single, 0);
    check(eot_irq == 1'b1, "R9 idle eot", eot_irq, 1);

    // Table walk: R4 R5 R6 R7 R8 R3
    foreach (VEC[k]) begin
      automatic logic       en   = VEC[k][10];
      automatic logic [2:0] sel  = VEC[k][9:7];
      automatic int         cnt  = int'(VEC[k][6:2]);
      automatic int         lvl  = en ? cnt : (cnt > 0 ? 1 : 0);
      drain();
      fifo_en = en; tx_trig_sel = sel; rx_trig_sel = sel;
      push_both(cnt, 8'h40);
      check(rx_level == 5'(lvl), "R3/R10 rx level", rx_level, lvl);
      check(tx_level == 5'(lvl), "R3/R10 tx level", tx_level, lvl);
      check(rx_irq == VEC[k][1], "R4/R5 rx irq", rx_irq, VEC[k][1]);
      check(tx_irq == VEC[k][0], "R4/R6 tx irq", tx_irq, VEC[k][0]);
      check(rx_dma_burst == VEC[k][1], "R5 rx burst", rx_dma_burst, VEC[k][1]);
      check(tx_dma_burst == VEC[k][0], "R6 tx burst", tx_dma_burst, VEC[k][0]);
      check(rx_dma_single == (lvl > 0), "R7 rx single", rx_dma_single, lvl > 0);
      check(tx_dma_single == (en ? lvl < 16 : lvl == 0), "R8 tx single", tx_dma_single,
            en ? lvl < 16 : lvl == 0);
    end

    // R1 ordering, R2 refusal when full
    drain();
    fifo_en = 1'b1;
    push_both(16, 8'h80);
    check(tx_full && !tx_in_ready, "R2 full blocks", {tx_full, tx_in_ready}, 2'b10);
    check(rx_full == 1'b1, "R10 rx full flag", rx_full, 1);
    push_both(1, 8'hEE);
    check(rx_level == 16, "R2 ignored write level", rx_level, 16);
    for (int i = 0; i < 16; i++) begin
      check(rx_out_valid && rx_out_data == 8'(8'h80 + i), "R1 rx order", rx_out_data, 8'h80 + i);
      check(tx_out_data == 8'(8'h80 + i), "R1 tx order", tx_out_data, 8'h80 + i);
      rx_out_ready = 1'b1; tx_out_ready = 1'b1;
      @(negedge clk);
    end
    rx_out_ready = 1'b0; tx_out_ready = 1'b0;
    check(rx_empty && !rx_out_valid, "R2 empty no valid", rx_out_valid, 0);

    // R2 concurrent read and write
    push_both(5, 8'h10);
    rx_in_valid = 1'b1; rx_in_data = 8'h55; rx_out_ready = 1'b1;
    @(negedge clk);
    rx_in_valid = 1'b0; rx_out_ready = 1'b0;
    check(rx_level == 5, "R2 push+pop level", rx_level, 5);
    check(rx_out_data == 8'h11, "R1 head after pop", rx_out_data, 8'h11);

    // R3 holding mode keeps the first byte
    drain();
    fifo_en = 1'b0;
    push_both(1, 8'hA1);
    push_both(1, 8'hB2);
    check(rx_out_data == 8'hA1 && !rx_in_ready, "R3 second write refused", rx_out_data, 8'hA1);

    // R9 end of transmission
    drain();
    fifo_en = 1'b1;
    shift_busy = 1'b1;
    @(negedge clk);
    check(eot_irq == 1'b0, "R9 busy shifter", eot_irq, 0);
    shift_busy = 1'b0;
    push_both(1, 8'h01);
    check(eot_irq == 1'b0, "R9 queue not empty", eot_irq, 0);
    drain();
    check(eot_irq == 1'b1, "R9 drained and idle", eot_irq, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule